// File: doc/BRIEF.md
# DMA Channel Address Register Bank

This block holds the address state of a four-channel DMA engine in the legacy ISA style. Each channel keeps a 16-bit base address and a 16-bit current address. A host CPU reaches these registers through an 8-bit I/O port. It moves one byte per access, and a single byte-pointer flip-flop shared by all channels picks the low or the high half. A read-only status byte reports which channels have hit terminal count and which have a request pending.

On the transfer side, each channel has a step strobe that moves its current address by one. It also has direction and autoinitialize settings and a terminal-count qualifier. When terminal count arrives with autoinitialize set, the current address is reloaded from the preserved base value instead of being stepped. For each channel the bank drives a 24-bit address, formed by placing an externally supplied page byte above the current address.

The CPU port uses plain single-cycle strobes and has no back-pressure. Every strobe completes in the cycle it is asserted. The transfer-side strobes are likewise accepted on every cycle. `cpu_wr` and `cpu_rd` are not asserted together.

Top module: `dma_addr_bank`

## Requirements
- R1: Port offset map: the address register of channel n is at offset 2n (0x0, 0x2, 0x4, 0x6), and the status byte is at 0x8. A read of any other offset returns 0x00, and a write to any other offset, apart from the two commands in R2, changes no register.
- R2: A write to offset 0xC (clear pointer) or 0xD (master clear) sets the byte pointer to low. Each read or write of an address-register offset toggles the pointer once, so the next access takes the other half. Accesses to any other offset leave the pointer unchanged.
- R3: A CPU write stores `cpu_wdata` into the pointer-selected byte of both the base and the current register of the addressed channel. A CPU read returns the pointer-selected byte of the current register in the same cycle (pointer low = bits 7:0, high = bits 15:8).
- R4: A step strobe for a channel changes its current address at the next clock edge: +1 when `xfer_dir_down` is 0 and −1 when it is 1, wrapping modulo 2^16.
- R5: A step strobe together with that channel's terminal-count qualifier and autoinitialize setting reloads the current address from the base address, and the base is left unchanged. Without autoinitialize, a terminal-count step steps normally.
- R6: Status bit n (bits 3:0) sets at the clock edge after a step strobe with terminal count on channel n. It holds until a status read, a master clear or reset clears it. The read returns the bits as they were before the clear. A set in the same cycle as a clear wins.
- R7: Status bits 7:4 show the live `dreq` inputs for channels 0 to 3 in the cycle of the read. They are not latched.
- R8: `ch_addr` slice n is {page byte n, current address n}. It follows the current register with no added delay.
- R9: When a CPU write targets a channel in the same cycle as its step strobe, the write takes effect and the step is dropped. A terminal-count status bit still sets.
- R10: After reset the byte pointer is low and all terminal-count status bits are 0. Address contents are undefined until written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_offs | input | 4 | CPU port offset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | CPU read byte, valid while `cpu_rd` is high, else 0 |
| xfer_step | input | 4 | Per-channel transfer-done strobe |
| xfer_tc | input | 4 | Per-channel terminal-count qualifier for the step |
| xfer_dir_down | input | 4 | Per-channel direction, 1 = decrement |
| xfer_autoinit | input | 4 | Per-channel autoinitialize enable |
| dreq | input | 4 | Per-channel request lines |
| page_in | input | 32 | Page byte per channel, channel n at bits 8n+7:8n |
| ch_addr | output | 96 | 24-bit address per channel, channel n at bits 24n+23:24n |

## Verification
Read data and status-request bits are combinational, so they are due in the cycle the read strobe is high. The bench compares them a few nanoseconds after it drives inputs on the falling edge. Address stepping, reloads, CPU byte writes, pointer changes and terminal-count flags all take effect at the next rising edge. The bench's reference model advances only at that edge, so its expectations line up with the registered outputs one cycle after the stimulus. `ch_addr` follows the register with no delay, and it is compared on every cycle for each channel whose two address bytes have been written.

// File: rtl/dma_bank_pkg.sv
package dma_bank_pkg;

  // Port offset width and the fixed command/status offsets.
  localparam int OFFS_W = 4;
  localparam logic [OFFS_W-1:0] OFFS_STATUS  = 4'h8;
  localparam logic [OFFS_W-1:0] OFFS_CLR_PTR = 4'hC;
  localparam logic [OFFS_W-1:0] OFFS_MCLR    = 4'hD;

  // Decoded CPU access for one cycle.
  typedef struct packed {
    logic addr_hit;   // address-register offset
    logic stat_hit;   // status offset
    logic ptr_clr;    // clear pointer or master clear written
    logic mclr;       // master clear written
    logic addr_wr;    // write to an address register
    logic addr_acc;   // read or write of an address register
    logic stat_rd;    // read of status
  } dma_dec_t;

endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk,
  input  logic rst_n,
  input  logic toggle,
  input  logic clear,
  output logic hi_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
    end else if (clear) begin
      hi_q <= 1'b0;
    end else if (toggle) begin
      hi_q <= ~hi_q;
    end
  end

endmodule

// File: rtl/dma_chan_addr.sv
module dma_chan_addr #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          wr_hi,
  input  logic [DW-1:0] wr_byte,
  input  logic          step,
  input  logic          tc,
  input  logic          autoinit,
  input  logic          dir_down,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] cur_q
);

  localparam logic [AW-1:0] ONE = AW'(1);

  // Address contents have no reset value; software programs them.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (wr_hi) begin
        base_q[AW-1:DW] <= wr_byte;
        cur_q[AW-1:DW]  <= wr_byte;
      end else begin
        base_q[DW-1:0]  <= wr_byte;
        cur_q[DW-1:0]   <= wr_byte;
      end
    end else if (step) begin
      if (tc && autoinit) begin
        cur_q <= base_q;
      end else if (dir_down) begin
        cur_q <= cur_q - ONE;
      end else begin
        cur_q <= cur_q + ONE;
      end
    end
  end

endmodule

// File: rtl/dma_tc_status.sv
module dma_tc_status #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_vec,
  input  logic              clr,
  output logic [NUM_CH-1:0] tc_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q <= '0;
    end else begin
      tc_q <= (clr ? '0 : tc_q) | set_vec;
    end
  end

endmodule

// File: rtl/dma_addr_bank.sv
module dma_addr_bank
  import dma_bank_pkg::*;
#(
  parameter int NUM_CH = 4,   // power of two, 2..4 (status fits one byte)
  parameter int AW     = 16,  // current/base width, two bytes
  parameter int DW     = 8,   // CPU port width
  parameter int PW     = 8    // page width
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [OFFS_W-1:0]        cpu_offs,
  input  logic                     cpu_wr,
  input  logic                     cpu_rd,
  input  logic [DW-1:0]            cpu_wdata,
  output logic [DW-1:0]            cpu_rdata,
  input  logic [NUM_CH-1:0]        xfer_step,
  input  logic [NUM_CH-1:0]        xfer_tc,
  input  logic [NUM_CH-1:0]        xfer_dir_down,
  input  logic [NUM_CH-1:0]        xfer_autoinit,
  input  logic [NUM_CH-1:0]        dreq,
  input  logic [NUM_CH*PW-1:0]     page_in,
  output logic [NUM_CH*(AW+PW)-1:0] ch_addr
);

  localparam int CW = $clog2(NUM_CH);
  localparam int OW = AW + PW;
  localparam logic [OFFS_W-1:0] ADDR_END = OFFS_W'(2 * NUM_CH);

  dma_dec_t             dec;
  logic [CW-1:0]        ch_sel;
  logic                 ptr_hi;
  logic [NUM_CH-1:0]    tc_q;
  logic [NUM_CH*AW-1:0] cur_flat;
  logic [NUM_CH*AW-1:0] base_flat;
  logic [AW-1:0]        rd_cur;
  logic [DW-1:0]        stat_word;

  // Offset decode (R1).
  assign ch_sel = cpu_offs[CW:1];

  always_comb begin
    dec          = '0;
    dec.addr_hit = !cpu_offs[0] && (cpu_offs < ADDR_END);
    dec.stat_hit = (cpu_offs == OFFS_STATUS);
    dec.mclr     = cpu_wr && (cpu_offs == OFFS_MCLR);
    dec.ptr_clr  = cpu_wr && ((cpu_offs == OFFS_CLR_PTR) || (cpu_offs == OFFS_MCLR));
    dec.addr_wr  = cpu_wr && dec.addr_hit;
    dec.addr_acc = (cpu_wr || cpu_rd) && dec.addr_hit;
    dec.stat_rd  = cpu_rd && dec.stat_hit;
  end

  // Shared byte pointer (R2, R10).
  dma_byte_ptr u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .toggle (dec.addr_acc),
    .clear  (dec.ptr_clr),
    .hi_q   (ptr_hi)
  );

  // Per-channel address registers (R3, R4, R5, R9).
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic wr_this;
    assign wr_this = dec.addr_wr && (ch_sel == CW'(i));

    dma_chan_addr #(.AW(AW), .DW(DW)) u_chan (
      .clk      (clk),
      .wr_en    (wr_this),
      .wr_hi    (ptr_hi),
      .wr_byte  (cpu_wdata),
      .step     (xfer_step[i]),
      .tc       (xfer_tc[i]),
      .autoinit (xfer_autoinit[i]),
      .dir_down (xfer_dir_down[i]),
      .base_q   (base_flat[i*AW +: AW]),
      .cur_q    (cur_flat[i*AW +: AW])
    );

    // Output address: page above current (R8).
    assign ch_addr[i*OW +: OW] = {page_in[i*PW +: PW], cur_flat[i*AW +: AW]};
  end

  // Terminal-count flags (R6, R10).
  dma_tc_status #(.NUM_CH(NUM_CH)) u_tc (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (xfer_step & xfer_tc),
    .clr     (dec.stat_rd || dec.mclr),
    .tc_q    (tc_q)
  );

  // Status byte: live requests above latched terminal counts (R6, R7).
  always_comb begin
    stat_word                      = '0;
    stat_word[NUM_CH-1:0]          = tc_q;
    stat_word[2*NUM_CH-1:NUM_CH]   = dreq;
  end

  // Read path (R1, R3).
  assign rd_cur = cur_flat[ch_sel*AW +: AW];

  always_comb begin
    cpu_rdata = '0;
    if (cpu_rd) begin
      if (dec.addr_hit) begin
        cpu_rdata = ptr_hi ? rd_cur[AW-1:DW] : rd_cur[DW-1:0];
      end else if (dec.stat_hit) begin
        cpu_rdata = stat_word;
      end
    end
  end

endmodule

// File: rtl/dma_addr_bank_chk.sv
module dma_addr_bank_chk
  import dma_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int AW     = 16,
  parameter int DW     = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [OFFS_W-1:0]    cpu_offs,
  input logic                 cpu_wr,
  input logic                 cpu_rd,
  input logic [DW-1:0]        cpu_wdata,
  input logic [DW-1:0]        cpu_rdata,
  input logic [NUM_CH-1:0]    xfer_step,
  input logic [NUM_CH-1:0]    xfer_tc,
  input logic [NUM_CH-1:0]    xfer_dir_down,
  input logic [NUM_CH-1:0]    xfer_autoinit,
  input logic [NUM_CH-1:0]    dreq,
  input logic                 ptr_hi,
  input logic [NUM_CH-1:0]    tc_q,
  input logic [NUM_CH*AW-1:0] cur_flat,
  input logic [NUM_CH*AW-1:0] base_flat
);

  localparam logic [OFFS_W-1:0] ADDR_END = OFFS_W'(2 * NUM_CH);
  localparam logic [AW-1:0]     ONE      = AW'(1);

  logic addr_acc, stat_rd, mclr_wr, clr_wr;
  assign addr_acc = (cpu_wr || cpu_rd) && !cpu_offs[0] && (cpu_offs < ADDR_END);
  assign stat_rd  = cpu_rd && (cpu_offs == OFFS_STATUS);
  assign mclr_wr  = cpu_wr && (cpu_offs == OFFS_MCLR);
  assign clr_wr   = cpu_wr && (cpu_offs == OFFS_CLR_PTR);

  p_ptr_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_acc |=> ptr_hi != $past(ptr_hi));

  p_ptr_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr || mclr_wr) |=> !ptr_hi);

  p_req_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |-> cpu_rdata[2*NUM_CH-1:NUM_CH] == dreq);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    logic wr_i;
    logic reload_i;
    assign wr_i     = cpu_wr && (cpu_offs == OFFS_W'(2 * i));
    assign reload_i = xfer_tc[i] && xfer_autoinit[i];

    p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_step[i] && !reload_i && !xfer_dir_down[i] && !wr_i)
      |=> cur_flat[i*AW +: AW] == $past(cur_flat[i*AW +: AW]) + ONE);

    p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_step[i] && !reload_i && xfer_dir_down[i] && !wr_i)
      |=> cur_flat[i*AW +: AW] == $past(cur_flat[i*AW +: AW]) - ONE);

    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_step[i] && reload_i && !wr_i)
      |=> (cur_flat[i*AW +: AW] == $past(base_flat[i*AW +: AW]))
          && $stable(base_flat[i*AW +: AW]));

    p_tc_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_step[i] && xfer_tc[i]) |=> tc_q[i]);

    p_tc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_q[i] && !stat_rd && !mclr_wr) |=> tc_q[i]);

    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && xfer_step[i] && !ptr_hi)
      |=> cur_flat[i*AW +: DW] == $past(cpu_wdata));
  end

endmodule

bind dma_addr_bank dma_addr_bank_chk #(.NUM_CH(NUM_CH), .AW(AW), .DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_offs      (cpu_offs),
  .cpu_wr        (cpu_wr),
  .cpu_rd        (cpu_rd),
  .cpu_wdata     (cpu_wdata),
  .cpu_rdata     (cpu_rdata),
  .xfer_step     (xfer_step),
  .xfer_tc       (xfer_tc),
  .xfer_dir_down (xfer_dir_down),
  .xfer_autoinit (xfer_autoinit),
  .dreq          (dreq),
  .ptr_hi        (ptr_hi),
  .tc_q          (tc_q),
  .cur_flat      (cur_flat),
  .base_flat     (base_flat)
);

// File: tb/dma_addr_bank_bench.sv
module dma_addr_bank_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cpu_offs = '0;
  logic        cpu_wr = 1'b0;
  logic        cpu_rd = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic [3:0]  xfer_step = '0;
  logic [3:0]  xfer_tc = '0;
  logic [3:0]  xfer_dir_down = '0;
  logic [3:0]  xfer_autoinit = '0;
  logic [3:0]  dreq = '0;
  logic [31:0] page_in = '0;
  logic [95:0] ch_addr;

  always #10 clk = ~clk;

  dma_addr_bank u_dma_addr_bank (
    .clk(clk), .rst_n(rst_n), .cpu_offs(cpu_offs), .cpu_wr(cpu_wr),
    .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .xfer_step(xfer_step), .xfer_tc(xfer_tc), .xfer_dir_down(xfer_dir_down),
    .xfer_autoinit(xfer_autoinit), .dreq(dreq), .page_in(page_in),
    .ch_addr(ch_addr)
  );

  // Reference model state.
  logic [15:0] m_base [4];
  logic [15:0] m_cur  [4];
  bit          m_lo   [4];
  bit          m_hi   [4];
  bit          m_ptr;
  logic [3:0]  m_tc;
  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit is_addr(input logic [3:0] o);
    return !o[0] && (o < 4'h8);
  endfunction

  task automatic compare(input string tag);
    int exp;
    if (cpu_rd) begin
      if (is_addr(cpu_offs)) begin
        int ch = int'(cpu_offs) >> 1;
        if (m_lo[ch] && m_hi[ch]) begin
          exp = m_ptr ? int'(m_cur[ch][15:8]) : int'(m_cur[ch][7:0]);
          chk(cpu_rdata == 8'(exp), tag, cpu_rdata, exp);
        end
      end else if (cpu_offs == 4'h8) begin
        exp = int'({dreq, m_tc});
        chk(cpu_rdata == 8'(exp), tag, cpu_rdata, exp);
      end else begin
        chk(cpu_rdata == 8'h00, tag, cpu_rdata, 0);
      end
    end else begin
      chk(cpu_rdata == 8'h00, tag, cpu_rdata, 0);
    end
    for (int c = 0; c < 4; c++) begin
      if (m_lo[c] && m_hi[c]) begin
        exp = int'({page_in[c*8 +: 8], m_cur[c]});
        chk(ch_addr[c*24 +: 24] == 24'(exp), {tag, " R8"}, int'(ch_addr[c*24 +: 24]), exp);
      end
    end
  endtask

  task automatic model_edge();
    int wch = -1;
    logic [3:0] clr_tc;
    clr_tc = '0;
    if (cpu_wr && is_addr(cpu_offs)) begin
      wch = int'(cpu_offs) >> 1;
      if (m_ptr) begin
        m_base[wch][15:8] = cpu_wdata; m_cur[wch][15:8] = cpu_wdata; m_hi[wch] = 1;
      end else begin
        m_base[wch][7:0] = cpu_wdata; m_cur[wch][7:0] = cpu_wdata; m_lo[wch] = 1;
      end
    end
    for (int c = 0; c < 4; c++) begin
      if (xfer_step[c] && c != wch) begin
        if (xfer_tc[c] && xfer_autoinit[c]) m_cur[c] = m_base[c];
        else if (xfer_dir_down[c])          m_cur[c] = m_cur[c] - 16'd1;
        else                                m_cur[c] = m_cur[c] + 16'd1;
      end
    end
    if ((cpu_wr || cpu_rd) && is_addr(cpu_offs)) m_ptr = !m_ptr;
    if (cpu_wr && (cpu_offs == 4'hC || cpu_offs == 4'hD)) m_ptr = 0;
    if ((cpu_rd && cpu_offs == 4'h8) || (cpu_wr && cpu_offs == 4'hD)) clr_tc = 4'hF;
    m_tc = (m_tc & ~clr_tc) | (xfer_step & xfer_tc);
  endtask

  // Inputs are driven after the falling edge; compare, then advance at rising edge.
  task automatic tick(input string tag);
    #3;
    compare(tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle();
    cpu_wr = 0; cpu_rd = 0; xfer_step = '0; xfer_tc = '0;
  endtask

  task automatic wr(input logic [3:0] o, input logic [7:0] d, input string tag);
    idle(); cpu_offs = o; cpu_wdata = d; cpu_wr = 1; tick(tag); idle();
  endtask

  task automatic rd(input logic [3:0] o, input string tag);
    idle(); cpu_offs = o; cpu_rd = 1; tick(tag); idle();
  endtask

  task automatic prog(input int ch, input logic [15:0] v, input string tag);
    wr(4'(2 * ch), v[7:0], tag);
    wr(4'(2 * ch), v[15:8], tag);
  endtask

  task automatic stp(input logic [3:0] s, input logic [3:0] t, input string tag);
    idle(); xfer_step = s; xfer_tc = t; tick(tag); idle();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not finish)");
    summary();
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      m_base[c] = '0; m_cur[c] = '0; m_lo[c] = 0; m_hi[c] = 0;
    end
    m_ptr = 0; m_tc = '0;
    page_in = 32'h44_33_22_11;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // Reset state: status clear, pointer low.
    rd(4'h8, "R10 status after reset");
    prog(0, 16'h1234, "R10 pointer low after reset");
    rd(4'h0, "R10 first read low byte");
    rd(4'h0, "R2 second read high byte");

    // Program all channels and read back.
    prog(1, 16'hABCD, "R3 write ch1");
    prog(2, 16'hFFFF, "R3 write ch2");
    prog(3, 16'h0000, "R3 write ch3");
    for (int c = 0; c < 4; c++) begin
      rd(4'(2 * c), "R3 read low");
      rd(4'(2 * c), "R3 read high");
    end

    // Unused offsets: read zero, write ignored, pointer untouched.
    wr(4'h1, 8'h5A, "R1 write odd offset");
    wr(4'h9, 8'h5A, "R1 write offset 9");
    rd(4'h3, "R1 read odd offset");
    rd(4'hF, "R1 read offset F");
    rd(4'h2, "R1 ch1 low after ignored writes");
    rd(4'h2, "R1 ch1 high after ignored writes");

    // Clear pointer mid-sequence.
    rd(4'h4, "R2 half access");
    wr(4'hC, 8'h00, "R2 clear pointer");
    rd(4'h4, "R2 low after clear");
    rd(4'h8, "R2 status read no toggle");
    rd(4'h4, "R2 high after status read");

    // Stepping and wrap.
    xfer_dir_down = 4'b1010;
    stp(4'b0001, '0, "R4 ch0 up");
    stp(4'b0011, '0, "R4 ch0 up ch1 down");
    stp(4'b0100, '0, "R4 ch2 wrap up");
    stp(4'b1000, '0, "R4 ch3 wrap down");
    stp(4'b1111, '0, "R4 all step");

    // Autoinit reload and plain terminal count.
    xfer_autoinit = 4'b0001;
    stp(4'b0011, 4'b0011, "R5 ch0 reload ch1 tc plain");
    rd(4'h0, "R5 ch0 cur low after reload");
    rd(4'h0, "R5 ch0 cur high after reload");
    stp(4'b0001, '0, "R5 base kept, step again");
    stp(4'b0001, 4'b0001, "R5 second reload");

    // Status clear on read, set wins.
    rd(4'h8, "R6 status shows tc");
    rd(4'h8, "R6 status cleared");
    stp(4'b0100, 4'b0100, "R6 set ch2");
    idle(); cpu_offs = 4'h8; cpu_rd = 1; xfer_step = 4'b1000; xfer_tc = 4'b1000;
    tick("R6 read with set");
    idle();
    rd(4'h8, "R6 set survived read");
    stp(4'b0010, 4'b0010, "R6 set ch1");
    wr(4'hD, 8'h00, "R6 master clear");
    rd(4'h8, "R6 status after master clear");

    // Live requests.
    dreq = 4'b1010; rd(4'h8, "R7 dreq 1010");
    dreq = 4'b0101; rd(4'h8, "R7 dreq 0101");
    dreq = 4'b0000; rd(4'h8, "R7 dreq cleared");

    // Page byte changes.
    page_in = 32'hDEADBEEF; idle(); tick("R8 page change");
    page_in = 32'h00FF0180; idle(); tick("R8 page change 2");

    // CPU write wins over step on the same channel.
    idle(); cpu_offs = 4'h6; cpu_wr = 1; cpu_wdata = 8'h77;
    xfer_step = 4'b1001; xfer_tc = 4'b1000; tick("R9 write with step");
    idle();
    rd(4'h8, "R9 tc still set");
    wr(4'h6, 8'h88, "R9 high byte");
    rd(4'h6, "R9 readback low");
    rd(4'h6, "R9 readback high");

    // Mixed stimulus, compared every cycle.
    for (int n = 0; n < 400; n++) begin
      int r = int'($urandom_range(0, 15));
      idle();
      xfer_step = 4'($urandom); xfer_tc = 4'($urandom) & 4'($urandom);
      xfer_dir_down = 4'($urandom); xfer_autoinit = 4'($urandom);
      dreq = 4'($urandom); page_in = $urandom;
      if (r < 4) begin
        cpu_rd = 1; cpu_offs = 4'($urandom_range(0, 8));
      end else if (r < 6) begin
        cpu_wr = 1; cpu_offs = 4'(2 * $urandom_range(0, 3)); cpu_wdata = 8'($urandom);
      end else if (r == 6) begin
        cpu_wr = 1; cpu_offs = ($urandom_range(0, 1) != 0) ? 4'hC : 4'hD;
      end
      tick("R4 R5 R6 mixed");
    end
    idle();
    tick("R8 final");

    summary();
    $finish;
  end

endmodule